// File: doc/BRIEF.md
# Integer ALU with multiply result paths

This block is the single-cycle arithmetic unit of a small 32-bit RISC-V core. It takes two operands and a 4-bit operation code and produces one result in the same cycle, with no clock and no state. The result mux covers addition and subtraction, the bitwise operations, logical and arithmetic shifts, signed set-less-than, and both halves of a full-width multiply. The high half comes in signed and unsigned forms. A pass-through of the second operand lets the core write an upper immediate straight to a register.

The decode stage of the core places the operation code on `i_op`. It places the first source register or the program counter on `i_a`, and the second source register or an immediate on `i_b`. The core writes `o_result` back. The datapath width is a parameter. The multiplier can be built as one shared array or as a signed and an unsigned pair.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 returns `i_a + i_b`, modulo 2^32.
- R2: Operation code 12 returns `i_a - i_b`, modulo 2^32.
- R3: Code 7 returns bitwise AND, code 6 bitwise OR and code 4 bitwise XOR of the two operands.
- R4: Code 1 returns `i_a` shifted left by `i_b[4:0]`, filling with zeros.
- R5: Code 5 returns `i_a` shifted right by `i_b[4:0]`, filling with zeros.
- R6: Code 13 returns `i_a` shifted right by `i_b[4:0]`, filling with bit 31 of `i_a`.
- R7: Code 2 returns 1 when `i_a` is less than `i_b` as two's-complement values, else 0, with bits 31:1 always zero.
- R8: Code 8 returns bits 31:0 of the 64-bit product of the operands.
- R9: Code 9 returns bits 63:32 of the product with both operands taken as signed.
- R10: Code 10 returns bits 63:32 of the product with both operands taken as unsigned.
- R11: Code 15 returns `i_b` unchanged.
- R12: The unassigned codes 3, 11 and 14 return zero.
- R13: For the three shifts, bits 31:5 of `i_b` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_op | input | 4 | Operation code |
| i_a | input | 32 | First operand |
| i_b | input | 32 | Second operand, or shift amount in its low 5 bits |
| o_result | output | 32 | Operation result |

## Verification
Three kinds of case are hard to reach from random operands. One is set-less-than where the subtraction overflows, for example 0x7FFFFFFF against 0x80000000. Another is a signed high multiply with the most negative value on one or both sides. The third is an arithmetic shift by 31 of a negative value. The stimulus crosses a fixed set of corner operands exhaustively with every operation code to reach them. For shifts it also repeats each case with random upper bits in the shift operand and requires an identical result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SLL   = 4'd1,
      OP_SLT   = 4'd2,
      OP_XOR   = 4'd4,
      OP_SRL   = 4'd5,
      OP_OR    = 4'd6,
      OP_AND   = 4'd7,
      OP_MUL   = 4'd8,
      OP_MULH  = 4'd9,
      OP_MULHU = 4'd10,
      OP_SUB   = 4'd12,
      OP_SRA   = 4'd13,
      OP_PASSB = 4'd15
   } alu_op_e;
   localparam int OP_W = 4;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] i_a,
   input  logic [XLEN-1:0] i_b,
   input  logic            i_sub,
   output logic [XLEN-1:0] o_sum,
   output logic            o_lt
);
   localparam int MSB = XLEN - 1;
   logic [XLEN-1:0] b_eff;

   always_comb begin
      b_eff = i_b ^ {XLEN{i_sub}};
      o_sum = i_a + b_eff + {{(XLEN-1){1'b0}}, i_sub};
      // signs differ: the negative one is smaller; otherwise the difference sign decides
      o_lt  = (i_a[MSB] ^ i_b[MSB]) ? i_a[MSB] : o_sum[MSB];
   end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
   parameter int XLEN = 32,
   localparam int SW  = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] i_val,
   input  logic [SW-1:0]   i_amt,
   input  logic            i_left,
   input  logic            i_arith,
   output logic [XLEN-1:0] o_val
);
   logic [XLEN-1:0] stage [SW+1];
   logic [XLEN-1:0] rev_in;
   logic [XLEN-1:0] rev_out;
   logic            fill;

   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_rev
         assign rev_in[i]  = i_val[XLEN-1-i];
         assign rev_out[i] = stage[SW][XLEN-1-i];
      end
   endgenerate

   assign fill     = i_arith & ~i_left & i_val[XLEN-1];
   assign stage[0] = i_left ? rev_in : i_val;

   generate
      for (genvar g = 0; g < SW; g++) begin : g_stage
         localparam int D = 1 << g;
         assign stage[g+1] = i_amt[g] ? {{D{fill}}, stage[g][XLEN-1:D]} : stage[g];
      end
   endgenerate

   assign o_val = i_left ? rev_out : stage[SW];
endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul #(
   parameter int XLEN       = 32,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic [XLEN-1:0] i_a,
   input  logic [XLEN-1:0] i_b,
   input  logic            i_signed,
   output logic [XLEN-1:0] o_lo,
   output logic [XLEN-1:0] o_hi
);
   localparam int PW = 2 * XLEN;
   logic [PW-1:0] prod;
   logic [PW-1:0] ua, ub, sa, sb;

   assign ua = {{XLEN{1'b0}}, i_a};
   assign ub = {{XLEN{1'b0}}, i_b};
   assign sa = {{XLEN{i_a[XLEN-1]}}, i_a};
   assign sb = {{XLEN{i_b[XLEN-1]}}, i_b};

   generate
      if (SHARED_MUL) begin : g_shared
         // one array; operand extension chosen before it
         assign prod = (i_signed ? sa : ua) * (i_signed ? sb : ub);
      end else begin : g_split
         logic [PW-1:0] prod_s, prod_u;
         assign prod_s = sa * sb;
         assign prod_u = ua * ub;
         assign prod   = i_signed ? prod_s : prod_u;
      end
   endgenerate

   assign o_lo = prod[XLEN-1:0];
   assign o_hi = prod[PW-1:XLEN];
endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic [OP_W-1:0] i_op,
   input  logic [XLEN-1:0] i_a,
   input  logic [XLEN-1:0] i_b,
   output logic [XLEN-1:0] o_result
);
   localparam int SW = $clog2(XLEN);

   generate
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("int_alu: XLEN must be a power of two of at least 8");
      end
   endgenerate

   alu_op_e         op;
   logic            use_sub;
   logic [XLEN-1:0] sum;
   logic            lt;
   logic [XLEN-1:0] shv;
   logic [XLEN-1:0] mlo, mhi;

   assign op      = alu_op_e'(i_op);
   assign use_sub = (op == OP_SUB) || (op == OP_SLT);

   int_alu_addsub #(.XLEN(XLEN)) u_addsub (
      .i_a(i_a), .i_b(i_b), .i_sub(use_sub), .o_sum(sum), .o_lt(lt)
   );

   int_alu_shift #(.XLEN(XLEN)) u_shift (
      .i_val(i_a), .i_amt(i_b[SW-1:0]), .i_left(op == OP_SLL),
      .i_arith(op == OP_SRA), .o_val(shv)
   );

   int_alu_mul #(.XLEN(XLEN), .SHARED_MUL(SHARED_MUL)) u_mul (
      .i_a(i_a), .i_b(i_b), .i_signed(op == OP_MULH), .o_lo(mlo), .o_hi(mhi)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_SUB:         o_result = sum;
         OP_SLL, OP_SRL, OP_SRA: o_result = shv;
         OP_SLT:                 o_result = {{(XLEN-1){1'b0}}, lt};
         OP_XOR:                 o_result = i_a ^ i_b;
         OP_OR:                  o_result = i_a | i_b;
         OP_AND:                 o_result = i_a & i_b;
         OP_MUL:                 o_result = mlo;
         OP_MULH, OP_MULHU:      o_result = mhi;
         OP_PASSB:               o_result = i_b;
         default:                o_result = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
   import int_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic [OP_W-1:0] i_op,
   input logic [XLEN-1:0] i_a,
   input logic [XLEN-1:0] i_b,
   input logic [XLEN-1:0] o_result
);
   logic known;
   assign known = !$isunknown({i_op, i_a, i_b, o_result});

   always_comb begin
      if (known) begin
         if (i_op == OP_ADD)
            a_r1_add_sum: assert (o_result - i_b == i_a);
         if (i_op == OP_SUB)
            a_r2_sub_inverse: assert (o_result + i_b == i_a);
         if (i_op == OP_XOR)
            a_r3_xor_inverse: assert ((o_result ^ i_b) == i_a);
         if (i_op == OP_SLT)
            a_r7_slt_single_bit: assert (o_result[XLEN-1:1] == '0);
         if (i_op == OP_PASSB)
            a_r11_pass_b: assert (o_result == i_b);
         if (i_op == 4'd3 || i_op == 4'd11 || i_op == 4'd14)
            a_r12_unused_zero: assert (o_result == '0);
         if (i_op == OP_SRL && i_b[$clog2(XLEN)-1:0] != '0)
            a_r5_srl_top_zero: assert (o_result[XLEN-1] == 1'b0);
      end
   end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN)) u_chk (
   .i_op(i_op), .i_a(i_a), .i_b(i_b), .o_result(o_result)
);

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  op;
   logic [31:0] a, b;
   logic [31:0] res;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   int_alu dut (.i_op(op), .i_a(a), .i_b(b), .o_result(res));

   function automatic logic [31:0] ref_alu(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
      logic [63:0] p;
      case (c)
         4'd0:  return x + y;
         4'd12: return x - y;
         4'd7:  return x & y;
         4'd6:  return x | y;
         4'd4:  return x ^ y;
         4'd1:  return x << y[4:0];
         4'd5:  return x >> y[4:0];
         4'd13: return $signed(x) >>> y[4:0];
         4'd2:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         4'd8:  begin p = {32'd0, x} * {32'd0, y}; return p[31:0]; end
         4'd9:  begin p = 64'($signed(x)) * 64'($signed(y)); return p[63:32]; end
         4'd10: begin p = {32'd0, x} * {32'd0, y}; return p[63:32]; end
         4'd15: return y;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd0: return "R1";   4'd12: return "R2";
         4'd4, 4'd6, 4'd7: return "R3";
         4'd1: return "R4";   4'd5: return "R5";  4'd13: return "R6";
         4'd2: return "R7";   4'd8: return "R8";  4'd9: return "R9";
         4'd10: return "R10"; 4'd15: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, got, exp);
      end
   endtask

   task automatic run(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      op = c; a = x; b = y;
      #5;
      check(req_of(c), res, ref_alu(c, x, y));
   endtask

   task automatic shift_upper(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] first;
      @(negedge clk);
      op = c; a = x; b = y;
      #5 first = res;
      b = {$urandom() & 32'hFFFF_FFE0} | {27'd0, y[4:0]};
      #2;
      check("R13", res, first);
   endtask

   logic [31:0] corners [8];

   initial begin
      corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
      corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
      corners[4] = 32'h0000_0001; corners[5] = 32'h0000_001F;
      corners[6] = 32'h0000_0020; corners[7] = 32'hFFFF_FFE1;
      op = 4'd0; a = '0; b = '0;
      void'($urandom(32'h1BAD_5EED));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", res, 32'd0);   // idle state: add of zeros
      // directed edge cases
      run(4'd2, 32'h7FFF_FFFF, 32'h8000_0000);   // R7 overflowing subtract: not less
      run(4'd2, 32'h8000_0000, 32'h7FFF_FFFF);   // R7 less
      run(4'd9, 32'h8000_0000, 32'h8000_0000);   // R9
      run(4'd13, 32'h8000_0000, 32'd31);         // R6
      run(4'd5, 32'h8000_0000, 32'd31);          // R5
      run(4'd15, 32'hABCD_E000, 32'h1234_5000);  // R11
      for (int c = 0; c < 16; c++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run(4'(c), corners[i], corners[j]);
      for (int c = 0; c < 16; c++)
         for (int n = 0; n < 300; n++)
            run(4'(c), $urandom(), $urandom());
      for (int n = 0; n < 100; n++) begin
         shift_upper(4'd1, $urandom(), $urandom());
         shift_upper(4'd5, $urandom(), $urandom());
         shift_upper(4'd13, $urandom(), $urandom());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule